// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block runs the high-speed transmitter slew-rate calibration of a serial PHY port without software help. On a start request it turns on the port's ring oscillator and lets it settle. It then brings up a frequency meter on the selected channel with a fixed measurement window and polls the meter's valid flag at a fixed interval, up to a poll limit. It takes the meter count whether or not valid was seen, shuts the meter down, and turns that count into a 3-bit slew control code.

The code is the rounded quotient of a fixed constant divided by the count: 1024 window cycles × 26 (reference MHz) × 28, divided by the count with truncation, then divided by 1000 with rounding to nearest. A code above 7 is clamped to 7, and a zero count gives the default code 4. The code is written into the slew field of the PHY control word, the oscillator enable is cleared afterwards, and a one-cycle done pulse ends the run. All delays are counted in reference-clock ticks set by parameters.

Top module: `slew_cal_seq`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `doneOut`, `meterFreeRun`, `meterEnable`, `meterCycles`, `meterClkSel`, `phyCtrl` and `slewCode` are all zero.
- R2: A start request in idle sets the oscillator enable, which is bit 15 of `phyCtrl`, on the next edge. `meterFreeRun` rises exactly SETTLE_TICKS cycles after that.
- R3: While `meterEnable` is high, `meterCycles` reads 1024 and `meterClkSel` reads the channel captured at start. `meterEnable` rises only after `meterFreeRun` and is high only while `meterFreeRun` is high. `meterFreeRun` is high only while the oscillator enable is high.
- R4: `meterValid` is sampled every POLL_TICKS cycles after `meterEnable` rises. The first sample that finds it high ends the wait. After MAX_POLLS samples without valid, the count is read anyway, so `meterEnable` falls (j+1)·POLL_TICKS+1 cycles after it rose, where j is the index of the deciding sample.
- R5: After the count is read, `meterEnable` falls first and `meterFreeRun` falls exactly one cycle later.
- R6: For a nonzero count c, the code is min(7, (floor(745472 / c) + 500) / 1000) using integer division.
- R7: For a zero count, the code is 4.
- R8: The code is placed on `slewCode` and on `phyCtrl[14:12]` while the oscillator enable is still high. The oscillator enable clears exactly one cycle later. The field is not written before `meterFreeRun` falls, and `phyCtrl[11:0]` is always zero.
- R9: `doneOut` is high for exactly one cycle, starting in the cycle in which the oscillator enable first reads low. `busy` is high from the cycle after start through that cycle and low in the next.
- R10: A start request while `busy` is high has no effect. The running sequence keeps its captured channel and produces exactly one done pulse, and no new sequence begins afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request a calibration run (used only when idle) |
| chanSel | input | CH_W | Meter channel, captured at start |
| busy | output | 1 | A sequence is running |
| doneOut | output | 1 | One-cycle end-of-sequence pulse |
| meterFreeRun | output | 1 | Free-running meter clock enable |
| meterEnable | output | 1 | Frequency meter enable |
| meterCycles | output | CYC_W | Measurement window in reference cycles |
| meterClkSel | output | CH_W | Monitored clock select |
| meterValid | input | 1 | Meter result is valid |
| meterCount | input | CNT_W | Meter result |
| phyCtrl | output | 16 | PHY control word: bit 15 oscillator enable, bits 14:12 slew code |
| slewCode | output | 3 | Current slew control code |

## Verification
The properties assume that `meterCount` holds steady from the start of a run until done, and that the meter drives `meterValid` only while it is enabled. The bench's meter model sets the count before each start and leaves it alone, and it raises valid after a chosen delay counted from the meter-enable edge. Some delays are longer than the whole poll window, which forces the timeout path. Extra start pulses, with a changed channel, are sent only in the middle of a run, to exercise the ignore rule.

// File: rtl/slew_cal_pkg.sv
package slew_cal_pkg;

  // Strobes from the sequencer control to the datapath.
  typedef struct packed {
    logic setOsc;
    logic clrOsc;
    logic setFrun;
    logic clrFrun;
    logic loadProg;
    logic setMeter;
    logic clrMeter;
    logic latchChan;
    logic latchCount;
    logic loadSettle;
    logic loadPoll;
    logic pollClr;
    logic pollIncr;
    logic divStart;
    logic writeCode;
  } calStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PROG,
    ST_MEAS,
    ST_POLL,
    ST_MOFF,
    ST_FOFF,
    ST_DIV,
    ST_OSCOFF,
    ST_DONE
  } calState_t;

endpackage

// File: rtl/slew_cal_ctrl.sv
module slew_cal_ctrl
  import slew_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       meterValid,
  input  logic       timerDone,
  input  logic       pollLast,
  input  logic       divDone,
  output calStrobe_t stb,
  output logic       busy,
  output logic       doneOut
);

  calState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.setOsc     = 1'b1;
          stb.latchChan  = 1'b1;
          stb.loadSettle = 1'b1;
          stateNxt       = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (timerDone) begin
          stb.setFrun = 1'b1;
          stateNxt    = ST_PROG;
        end
      end
      ST_PROG: begin
        stb.loadProg = 1'b1;
        stateNxt     = ST_MEAS;
      end
      ST_MEAS: begin
        stb.setMeter = 1'b1;
        stb.loadPoll = 1'b1;
        stb.pollClr  = 1'b1;
        stateNxt     = ST_POLL;
      end
      ST_POLL: begin
        if (timerDone) begin
          if (meterValid || pollLast) begin
            stb.latchCount = 1'b1;
            stateNxt       = ST_MOFF;
          end else begin
            stb.pollIncr = 1'b1;
            stb.loadPoll = 1'b1;
          end
        end
      end
      ST_MOFF: begin
        stb.clrMeter = 1'b1;
        stateNxt     = ST_FOFF;
      end
      ST_FOFF: begin
        stb.clrFrun  = 1'b1;
        stb.divStart = 1'b1;
        stateNxt     = ST_DIV;
      end
      ST_DIV: begin
        if (divDone) begin
          stb.writeCode = 1'b1;
          stateNxt      = ST_OSCOFF;
        end
      end
      ST_OSCOFF: begin
        stb.clrOsc = 1'b1;
        stateNxt   = ST_DONE;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign doneOut = (state == ST_DONE);

endmodule

// File: rtl/slew_cal_dp.sv
module slew_cal_dp
  import slew_cal_pkg::*;
#(
  parameter int CH_W         = 2,
  parameter int CNT_W        = 24,
  parameter int CYC_W        = 24,
  parameter int CODE_W       = 3,
  parameter int SETTLE_TICKS = 26,
  parameter int POLL_TICKS   = 260,
  parameter int MAX_POLLS    = 20,
  parameter int FM_CYCLES    = 1024,
  parameter int REF_MHZ      = 26,
  parameter int SR_COEF      = 28,
  parameter int SR_DIV       = 1000,
  parameter int DEF_CODE     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        stb,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [CNT_W-1:0]  meterCount,
  output logic              timerDone,
  output logic              pollLast,
  output logic              divDone,
  output logic              oscEn,
  output logic              frunEn,
  output logic              meterEn,
  output logic [CYC_W-1:0]  meterCycles,
  output logic [CH_W-1:0]   meterClkSel,
  output logic [CODE_W-1:0] slewCode
);

  localparam int TMR_MAX = (SETTLE_TICKS > POLL_TICKS) ? SETTLE_TICKS : POLL_TICKS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PCNT_W  = $clog2(MAX_POLLS + 1);
  localparam int NUMER   = FM_CYCLES * REF_MHZ * SR_COEF;
  localparam int NUM_W   = $clog2(NUMER + 1);
  localparam int DCNT_W  = $clog2(NUM_W + 1);
  localparam int NSTEP   = (1 << CODE_W) - 1;

  localparam logic [TMR_W-1:0]  SETTLE_LD = TMR_W'(SETTLE_TICKS - 1);
  localparam logic [TMR_W-1:0]  POLL_LD   = TMR_W'(POLL_TICKS - 1);
  localparam logic [PCNT_W-1:0] POLL_LAST = PCNT_W'(MAX_POLLS - 1);
  localparam logic [NUM_W-1:0]  NUM_VAL   = NUM_W'(NUMER);
  localparam logic [DCNT_W-1:0] DIV_STEPS = DCNT_W'(NUM_W);

  // Shared tick timer for the settle wait and the poll interval.
  logic [TMR_W-1:0] tmrCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tmrCnt <= '0;
    else if (stb.loadSettle) tmrCnt <= SETTLE_LD;
    else if (stb.loadPoll)   tmrCnt <= POLL_LD;
    else if (tmrCnt != '0)   tmrCnt <= tmrCnt - 1'b1;
  end
  assign timerDone = (tmrCnt == '0);

  // Poll counter.
  logic [PCNT_W-1:0] pollCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pollCnt <= '0;
    else if (stb.pollClr)  pollCnt <= '0;
    else if (stb.pollIncr) pollCnt <= pollCnt + 1'b1;
  end
  assign pollLast = (pollCnt == POLL_LAST);

  // Register-style control bits toward the PHY and meter.
  logic [CH_W-1:0] chanReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscEn       <= 1'b0;
      frunEn      <= 1'b0;
      meterEn     <= 1'b0;
      meterCycles <= '0;
      meterClkSel <= '0;
      chanReg     <= '0;
    end else begin
      if (stb.setOsc)        oscEn   <= 1'b1;
      else if (stb.clrOsc)   oscEn   <= 1'b0;
      if (stb.setFrun)       frunEn  <= 1'b1;
      else if (stb.clrFrun)  frunEn  <= 1'b0;
      if (stb.setMeter)      meterEn <= 1'b1;
      else if (stb.clrMeter) meterEn <= 1'b0;
      if (stb.latchChan)     chanReg <= chanSel;
      if (stb.loadProg) begin
        meterCycles <= CYC_W'(FM_CYCLES);
        meterClkSel <= chanReg;
      end
    end
  end

  // Count capture.
  logic [CNT_W-1:0] countReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               countReg <= '0;
    else if (stb.latchCount) countReg <= meterCount;
  end

  // Restoring serial divider: NUMER / countReg, one quotient bit per cycle.
  logic [NUM_W-1:0]  quotReg;
  logic [CNT_W:0]    remReg;
  logic [DCNT_W-1:0] divCnt;
  logic [CNT_W:0]    remShift;
  logic              remFits;

  assign remShift = {remReg[CNT_W-1:0], quotReg[NUM_W-1]};
  assign remFits  = (remShift >= {1'b0, countReg});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotReg <= '0;
      remReg  <= '0;
      divCnt  <= '0;
    end else if (stb.divStart) begin
      quotReg <= NUM_VAL;
      remReg  <= '0;
      divCnt  <= DIV_STEPS;
    end else if (divCnt != '0) begin
      divCnt  <= divCnt - 1'b1;
      remReg  <= remFits ? (remShift - {1'b0, countReg}) : remShift;
      quotReg <= {quotReg[NUM_W-2:0], remFits};
    end
  end
  assign divDone = (divCnt == '0);

  // Round-to-nearest by SR_DIV with a clamp: count the thresholds reached.
  logic [NSTEP-1:0] geStep;
  for (genvar k = 1; k <= NSTEP; k++) begin : g_step
    localparam logic [31:0] THR = 32'(SR_DIV * k - SR_DIV / 2);
    assign geStep[k-1] = (32'(quotReg) >= THR);
  end

  logic [CODE_W-1:0] roundCode;
  always_comb begin
    roundCode = '0;
    for (int k = 0; k < NSTEP; k++) roundCode = roundCode + CODE_W'(geStep[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slewCode <= '0;
    else if (stb.writeCode)
      slewCode <= (countReg == '0) ? CODE_W'(DEF_CODE) : roundCode;
  end

endmodule

// File: rtl/slew_cal_seq.sv
module slew_cal_seq
  import slew_cal_pkg::*;
#(
  parameter int CH_W         = 2,
  parameter int CNT_W        = 24,
  parameter int CYC_W        = 24,
  parameter int SETTLE_TICKS = 26,
  parameter int POLL_TICKS   = 260,
  parameter int MAX_POLLS    = 20,
  parameter int FM_CYCLES    = 1024,
  parameter int REF_MHZ      = 26,
  parameter int SR_COEF      = 28,
  parameter int SR_DIV       = 1000,
  parameter int DEF_CODE     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CH_W-1:0]  chanSel,
  output logic             busy,
  output logic             doneOut,
  output logic             meterFreeRun,
  output logic             meterEnable,
  output logic [CYC_W-1:0] meterCycles,
  output logic [CH_W-1:0]  meterClkSel,
  input  logic             meterValid,
  input  logic [CNT_W-1:0] meterCount,
  output logic [15:0]      phyCtrl,
  output logic [2:0]       slewCode
);

  localparam int CODE_W = 3;

  calStrobe_t stb;
  logic timerDone, pollLast, divDone, oscEn;

  slew_cal_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .meterValid(meterValid),
    .timerDone (timerDone),
    .pollLast  (pollLast),
    .divDone   (divDone),
    .stb       (stb),
    .busy      (busy),
    .doneOut   (doneOut)
  );

  slew_cal_dp #(
    .CH_W        (CH_W),
    .CNT_W       (CNT_W),
    .CYC_W       (CYC_W),
    .CODE_W      (CODE_W),
    .SETTLE_TICKS(SETTLE_TICKS),
    .POLL_TICKS  (POLL_TICKS),
    .MAX_POLLS   (MAX_POLLS),
    .FM_CYCLES   (FM_CYCLES),
    .REF_MHZ     (REF_MHZ),
    .SR_COEF     (SR_COEF),
    .SR_DIV      (SR_DIV),
    .DEF_CODE    (DEF_CODE)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .chanSel    (chanSel),
    .meterCount (meterCount),
    .timerDone  (timerDone),
    .pollLast   (pollLast),
    .divDone    (divDone),
    .oscEn      (oscEn),
    .frunEn     (meterFreeRun),
    .meterEn    (meterEnable),
    .meterCycles(meterCycles),
    .meterClkSel(meterClkSel),
    .slewCode   (slewCode)
  );

  // Bit 15: oscillator calibration enable; bits 14:12: slew code.
  assign phyCtrl = {oscEn, slewCode, 12'h000};

endmodule

// File: rtl/slew_cal_chk.sv
module slew_cal_chk #(
  parameter int CH_W      = 2,
  parameter int CYC_W     = 24,
  parameter int FM_CYCLES = 1024
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             doneOut,
  input logic             meterFreeRun,
  input logic             meterEnable,
  input logic [CYC_W-1:0] meterCycles,
  input logic [CH_W-1:0]  meterClkSel,
  input logic [15:0]      phyCtrl,
  input logic [2:0]       slewCode
);

  AST_METER_INSIDE_FRUN: assert property (@(posedge clk) disable iff (!rstN)
    meterEnable |-> meterFreeRun); // R3
  AST_FRUN_INSIDE_OSC: assert property (@(posedge clk) disable iff (!rstN)
    meterFreeRun |-> phyCtrl[15]); // R3
  AST_WINDOW_PROGRAMMED: assert property (@(posedge clk) disable iff (!rstN)
    meterEnable |-> (meterCycles == CYC_W'(FM_CYCLES))); // R3
  AST_CLKSEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (meterEnable && $past(meterEnable)) |-> $stable(meterClkSel)); // R10
  AST_CODE_WRITTEN_WITH_OSC: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(slewCode) |-> phyCtrl[15]); // R8
  AST_FIELD_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (phyCtrl[14:12] == slewCode) && (phyCtrl[11:0] == 12'h000)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R9
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !busy); // R9

endmodule

bind slew_cal_seq slew_cal_chk #(
  .CH_W     (CH_W),
  .CYC_W    (CYC_W),
  .FM_CYCLES(FM_CYCLES)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .doneOut     (doneOut),
  .meterFreeRun(meterFreeRun),
  .meterEnable (meterEnable),
  .meterCycles (meterCycles),
  .meterClkSel (meterClkSel),
  .phyCtrl     (phyCtrl),
  .slewCode    (slewCode)
);

// File: tb/sim_slew_cal_seq.sv
module sim_slew_cal_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CH_W   = 2;
  localparam int CNT_W  = 24;
  localparam int CYC_W  = 24;
  localparam int SETTLE = 6;
  localparam int POLL   = 10;
  localparam int MAXP   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [CH_W-1:0] chanSel = '0;
  logic meterValid = 1'b0;
  logic [CNT_W-1:0] meterCount = '0;
  logic busy, doneOut, meterFreeRun, meterEnable;
  logic [CYC_W-1:0] meterCycles;
  logic [CH_W-1:0] meterClkSel;
  logic [15:0] phyCtrl;
  logic [2:0] slewCode;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slew_cal_seq #(
    .CH_W(CH_W), .CNT_W(CNT_W), .CYC_W(CYC_W),
    .SETTLE_TICKS(SETTLE), .POLL_TICKS(POLL), .MAX_POLLS(MAXP)
  ) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanSel(chanSel),
    .busy(busy), .doneOut(doneOut), .meterFreeRun(meterFreeRun),
    .meterEnable(meterEnable), .meterCycles(meterCycles),
    .meterClkSel(meterClkSel), .meterValid(meterValid),
    .meterCount(meterCount), .phyCtrl(phyCtrl), .slewCode(slewCode)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(input int c);
    int q, r;
    if (c == 0) return 4;
    q = 745472 / c;
    r = (q + 500) / 1000;
    return (r > 7) ? 7 : r;
  endfunction

  function automatic int expPollIdx(input int d);
    for (int j = 0; j < MAXP; j++) if ((j + 1) * POLL - 1 >= d) return j;
    return MAXP - 1;
  endfunction

  // One calibration run; inputs driven and outputs sampled on falling edges.
  task automatic runCal(input int cnt, input int chan, input int vDelay, input bit intrude);
    int s = 0;
    int oscRise = -1, frunRise = -1, meterRise = -1, meterFall = -1;
    int frunFall = -1, oscFall = -1, doneRise = -1, doneCnt = 0;
    int cycAtRise = 0, selAtRise = 0, codeAtFrunFall = 0, codeBeforeOscOff = 0;
    int startCode;
    logic pOsc = 1'b0, pFrun = 1'b0, pMeter = 1'b0, pDone = 1'b0;
    logic [2:0] pCode;
    int jExp, ec;
    startCode  = int'(slewCode);
    pCode      = slewCode;
    meterCount = CNT_W'(cnt);
    chanSel    = CH_W'(chan);
    startReq   = 1'b1;
    while (s < 3000) begin
      @(negedge clk);
      s++;
      startReq = (intrude && (s == 3 || s == 20)) ? 1'b1 : 1'b0;
      if (intrude && s == 3) chanSel = CH_W'(chan ^ 1);
      if (phyCtrl[15] && !pOsc && oscRise < 0) oscRise = s;
      if (meterFreeRun && !pFrun && frunRise < 0) frunRise = s;
      if (meterEnable && !pMeter && meterRise < 0) begin
        meterRise = s; cycAtRise = int'(meterCycles); selAtRise = int'(meterClkSel);
      end
      if (!meterEnable && pMeter && meterFall < 0) meterFall = s;
      if (!meterFreeRun && pFrun && frunFall < 0) begin
        frunFall = s; codeAtFrunFall = int'(slewCode);
      end
      if (!phyCtrl[15] && pOsc && oscFall < 0) begin
        oscFall = s; codeBeforeOscOff = int'(pCode);
      end
      if (doneOut) doneCnt++;
      if (doneOut && !pDone && doneRise < 0) doneRise = s;
      meterValid = (meterRise >= 0 && meterFall < 0 && (s - meterRise) >= vDelay);
      pOsc = phyCtrl[15]; pFrun = meterFreeRun; pMeter = meterEnable;
      pDone = doneOut; pCode = slewCode;
      if (doneRise >= 0 && s > doneRise + 1) break;
    end
    meterValid = 1'b0;
    ec   = expCode(cnt);
    jExp = expPollIdx(vDelay);
    chk(oscRise == 1, "R2 oscillator enable after start", oscRise, 1);
    chk(frunRise - oscRise == SETTLE, "R2 settle time", frunRise - oscRise, SETTLE);
    chk(meterRise > frunRise, "R3 meter after free-run", meterRise, frunRise + 1);
    chk(cycAtRise == 1024, "R3 window cycles", cycAtRise, 1024);
    chk(selAtRise == chan, "R3 R10 clock select", selAtRise, chan);
    chk(meterFall - meterRise == (jExp + 1) * POLL + 1, "R4 poll decision",
        meterFall - meterRise, (jExp + 1) * POLL + 1);
    chk(frunFall == meterFall + 1, "R5 disable order", frunFall, meterFall + 1);
    chk(codeAtFrunFall == startCode, "R8 field untouched before shutdown",
        codeAtFrunFall, startCode);
    chk(codeBeforeOscOff == ec, (cnt == 0) ? "R7 default code" : "R6 computed code",
        codeBeforeOscOff, ec);
    chk(int'(slewCode) == ec && int'(phyCtrl[14:12]) == ec && phyCtrl[11:0] == 12'h000,
        "R8 field placement", int'(phyCtrl), ec << 12);
    chk(doneRise == oscFall, "R9 done timing", doneRise, oscFall);
    chk(doneCnt == 1, "R9 R10 single done", doneCnt, 1);
    chk(!busy && !doneOut, "R9 idle after done", busy, 0);
    if (intrude) begin
      int late = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (phyCtrl[15] || busy) late++;
      end
      chk(late == 0, "R10 no restart from ignored start", late, 0);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !doneOut && !meterFreeRun && !meterEnable && phyCtrl == 16'h0 &&
        meterCycles == '0 && meterClkSel == '0 && slewCode == 3'd0,
        "R1 state in reset", int'(phyCtrl), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !doneOut && !meterFreeRun && !meterEnable && phyCtrl == 16'h0 &&
        slewCode == 3'd0, "R1 state after reset", int'(phyCtrl), 0);
    // Directed corner cases.
    runCal(1000, 1, 0, 1'b0);     // R6 code 1, valid at first poll point
    runCal(0, 2, 3, 1'b0);        // R7 zero count
    runCal(1, 3, 1000, 1'b0);     // R6 clamp at 7, R4 timeout path
    runCal(1490, 0, 12, 1'b0);    // R6 rounding boundary, rounds up to 1
    runCal(1491, 1, 25, 1'b0);    // R6 rounding boundary, rounds down to 0
    runCal(200, 2, 9, 1'b1);      // R10 start while busy
    runCal(2000, 0, 39, 1'b0);    // R4 last poll point
    // Constrained random runs.
    for (int n = 0; n < 16; n++) begin
      int c, ch, d;
      c  = (n % 5 == 0) ? int'($urandom_range(1, 120)) : int'($urandom_range(90, 3000));
      ch = int'($urandom_range(0, 3));
      d  = int'($urandom_range(0, 50));
      runCal(c, ch, d, (n % 4 == 1));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule